// File: doc/BRIEF.md
# Receive Queue with Watermark Transfer Request

This block is the receive-side queue of a serial port. Words from the deserializer enter through a valid/ready push port and are held in order. Software takes them out with a data-register read strobe, and a DMA engine takes them out with an acknowledge strobe. The oldest word is always shown on the read-data output, so the reader samples it in the same cycle that it strobes.

Two status flags come from the fill level. A full flag marks a queue with no free entry. A transfer-request flag compares the level against a programmable watermark, with hysteresis, and it drops for at least one cycle after every DMA access. Each flag can drive a shared, registered interrupt through its own enable. While the receiver is disabled, both flags read as zero.

Back-pressure rules: `in_ready` is high whenever fewer than DEPTH words are held. A word is taken on any clock edge where `in_valid` and `in_ready` are both high. The deserializer cannot stall, so a word offered while `in_ready` is low is discarded and the sticky overflow bit is set. The pop side uses plain strobes without a handshake. `cpu_rd` and `dma_ack` in the same cycle remove a single word.

Top module: `rx_fifo_dreq`

## Requirements
- R1: Accepted words leave in arrival order. `rd_data` shows the oldest held word, and `in_ready` is 1 exactly when `level` is below DEPTH (default 16).
- R2: A word offered with `in_valid` while the queue is full is dropped, and `level` is unchanged. It sets the overflow bit, status bit 2, which then stays 1 until reset.
- R3: A pop is `cpu_rd` or `dma_ack`, or both (one word removed). A pop on an empty queue leaves `level` at 0, and `rd_data` reads 0.
- R4: The full flag, status bit 0, is 1 after the edge on which `level` becomes DEPTH. It clears after the edge of a CPU read that takes the level below DEPTH.
- R5: The transfer-request flag, status bit 1, is set after an edge that leaves `level` greater than `wm` (valid range 1 to DEPTH).
- R6: The transfer-request flag clears after an edge that leaves `level` below `wm`. When `level` equals `wm`, the flag keeps its previous value.
- R7: A cycle with `dma_ack` high makes the transfer-request flag 0 after that edge. On the next edge it is set again if `level` is still greater than `wm`.
- R8: While `rx_en` is 0, status bits 0 and 1 read 0 after the next edge. Storage and `level` are unaffected.
- R9: `irq` is registered. After each edge it equals (full flag AND `ie_full`) OR (request flag AND `ie_req`), using the flag values from before that edge.
- R10: Status bits 7 to 3 always read 0.
- R11: A push and a pop in the same cycle, on a queue that is neither empty nor full, leave `level` unchanged and keep the word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; gates the status flags |
| in_valid | input | 1 | Deserializer offers a word |
| in_data | input | WIDTH (16) | Offered word |
| in_ready | output | 1 | Room for a word |
| cpu_rd | input | 1 | Software read strobe of the data register |
| dma_ack | input | 1 | DMA read access strobe |
| rd_data | output | WIDTH (16) | Oldest held word, 0 when empty |
| wm | input | CW (5) | Watermark level |
| ie_full | input | 1 | Interrupt enable for the full flag |
| ie_req | input | 1 | Interrupt enable for the transfer-request flag |
| status | output | 8 | {5'b0, overflow, request, full} |
| level | output | CW (5) | Number of held words |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. One pair is a push and a pop on a partly filled queue. The other is a DMA access and a level that still lies above the watermark. The bench drives both in one strobe cycle. It then judges the level, the word order seen at `rd_data`, and the drop-and-reassert pattern of the request bit across the two edges that follow. It also offers a word to a full queue while a CPU read is present, and checks that the word is dropped, the overflow bit is set, and the full flag clears.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ST_W    = 8;
  localparam int ST_FULL = 0;
  localparam int ST_REQ  = 1;
  localparam int ST_OVF  = 2;

  typedef struct packed {
    logic full;
    logic req;
  } rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_vld,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             ready,
  output logic [WIDTH-1:0] head_data,
  output logic [CW-1:0]    cnt,
  output logic [CW-1:0]    cnt_nxt,
  output logic             ovf
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ix, rd_ix;
  logic             is_full, is_empty, do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] ix);
    return (ix == LAST_IX) ? '0 : ix + AW'(1);
  endfunction

  assign is_full  = (cnt == FULL_LVL);
  assign is_empty = (cnt == '0);
  assign do_push  = push_vld && !is_full;
  assign do_pop   = pop && !is_empty;
  assign ready    = !is_full;

  always_comb begin
    cnt_nxt = cnt;
    case ({do_push, do_pop})
      2'b10:   cnt_nxt = cnt + CW'(1);
      2'b01:   cnt_nxt = cnt - CW'(1);
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ix] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ix <= '0;
      rd_ix <= '0;
      cnt   <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wr_ix <= bump(wr_ix);
      if (do_pop)  rd_ix <= bump(rd_ix);
      cnt <= cnt_nxt;
      if (push_vld && is_full) ovf <= 1'b1;
    end
  end

  assign head_data = is_empty ? '0 : mem[rd_ix];

  a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL_LVL);
  a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf);
  a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push_vld && is_empty) |=> (cnt == '0));
  a_r11_pushpop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && pop && !is_empty && !is_full) |=> $stable(cnt));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        dma_ack,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] wm,
  output rxq_flags_t  fl
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  rxq_flags_t fl_nxt;

  always_comb begin
    fl_nxt.full = rx_en && (cnt_nxt == FULL_LVL);
    if (!rx_en || dma_ack)  fl_nxt.req = 1'b0;
    else if (cnt_nxt > wm)  fl_nxt.req = 1'b1;
    else if (cnt_nxt < wm)  fl_nxt.req = 1'b0;
    else                    fl_nxt.req = fl.req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl <= '0;
    else        fl <= fl_nxt;
  end

  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!fl.full && !fl.req));
  a_r7_dma_drop: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !fl.req);
  a_r6_below: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_nxt < wm) |=> !fl.req);
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rxq_flags_t fl,
  input  logic       ie_full,
  input  logic       ie_req,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (fl.full && ie_full) || (fl.req && ie_req);
  end

  a_r9_full_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (fl.full && ie_full) |=> irq);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_full && !ie_req) |=> !irq);
endmodule

// File: rtl/rx_fifo_dreq.sv
module rx_fifo_dreq
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  input  logic             cpu_rd,
  input  logic             dma_ack,
  output logic [WIDTH-1:0] rd_data,
  input  logic [CW-1:0]    wm,
  input  logic             ie_full,
  input  logic             ie_req,
  output logic [ST_W-1:0]  status,
  output logic [CW-1:0]    level,
  output logic             irq
);
  logic [CW-1:0] cnt, cnt_nxt;
  logic          ovf;
  rxq_flags_t    fl;

  rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_vld(in_valid), .push_data(in_data),
    .pop(cpu_rd || dma_ack),
    .ready(in_ready), .head_data(rd_data),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .ovf(ovf)
  );

  rxq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dma_ack(dma_ack),
    .cnt_nxt(cnt_nxt), .wm(wm), .fl(fl)
  );

  rxq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .fl(fl),
    .ie_full(ie_full), .ie_req(ie_req), .irq(irq)
  );

  always_comb begin
    status          = '0;
    status[ST_FULL] = fl.full;
    status[ST_REQ]  = fl.req;
    status[ST_OVF]  = ovf;
  end

  assign level = cnt;

  a_r4_full_level: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_FULL] |-> (level == CW'(DEPTH)));
  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_W-1:3] == '0);
endmodule

// File: tb/sim_rx_fifo_dreq.sv
module sim_rx_fifo_dreq;
  localparam int PER   = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, in_valid = 1'b0, cpu_rd = 1'b0, dma_ack = 1'b0;
  logic ie_full = 1'b0, ie_req = 1'b0;
  logic [WIDTH-1:0] in_data = '0;
  logic [CW-1:0] wm = CW'(4);
  logic in_ready, irq;
  logic [WIDTH-1:0] rd_data;
  logic [7:0] status;
  logic [CW-1:0] level;

  int total = 0, bad = 0;
  logic [WIDTH-1:0] exp_q[$];
  int  m_cnt = 0;
  bit  m_full = 0, m_req = 0, m_ovf = 0;

  always #(PER/2) clk = ~clk;

  rx_fifo_dreq #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .cpu_rd(cpu_rd),
    .dma_ack(dma_ack), .rd_data(rd_data), .wm(wm), .ie_full(ie_full),
    .ie_req(ie_req), .status(status), .level(level), .irq(irq)
  );

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor side of the scoreboard: compares the shown head word with the queue.
  task automatic expect_pop();
    logic [WIDTH-1:0] e;
    if (exp_q.size() == 0) check("R3 empty read data", rd_data, 0);
    else begin
      e = exp_q.pop_front();
      check("R1 order", rd_data, e);
    end
  endtask

  // One cycle of stimulus plus model update and port checks after the edge.
  task automatic step(bit v, logic [WIDTH-1:0] d, bit cr, bit da, string tag);
    bit pop, pushed, irq_exp;
    pop = cr | da;
    in_valid = v; in_data = d; cpu_rd = cr; dma_ack = da;
    #1;
    check("R1 ready", in_ready, (m_cnt < DEPTH));
    if (pop) expect_pop();
    pushed = v && (m_cnt < DEPTH);
    if (v && !pushed) m_ovf = 1;
    if (pushed) exp_q.push_back(d);
    irq_exp = (m_full && ie_full) || (m_req && ie_req);
    if (pushed && !(pop && m_cnt > 0)) m_cnt++;
    else if (!pushed && pop && m_cnt > 0) m_cnt--;
    m_full = rx_en && (m_cnt == DEPTH);
    if (!rx_en || da) m_req = 0;
    else if (m_cnt > wm) m_req = 1;
    else if (m_cnt < wm) m_req = 0;
    @(posedge clk); #1;
    in_valid = 0; cpu_rd = 0; dma_ack = 0;
    check("R11 level", level, m_cnt);
    check({tag, " full"}, status[0], m_full);
    check({tag, " request"}, status[1], m_req);
    check("R2 overflow", status[2], m_ovf);
    check("R10 reserved", status[7:3], 0);
    check("R9 irq", irq, irq_exp);
  endtask

  initial begin
    #(PER * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R10 reset status", status, 0);
    check("R3 reset level", level, 0);
    check("R9 reset irq", irq, 0);
    check("R1 reset ready", in_ready, 1);
    rst_n = 1'b1;
    rx_en = 1'b1;
    @(posedge clk); #1;
    // R5: request rises once level passes wm=4; R4: full at 16
    for (int i = 0; i < DEPTH; i++) step(1, WIDTH'(16'hA000 + i), 0, 0, "R5");
    check("R4 full set", status[0], 1);
    // R2: push to full queue with CPU read in same cycle: dropped, full clears
    step(1, 16'hDEAD, 1, 0, "R4");
    check("R2 dropped level", level, DEPTH - 1);
    step(1, 16'h00F0, 0, 0, "R4");
    check("R4 full again", status[0], 1);
    ie_full = 1;
    step(0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");
    check("R9 irq from full", irq, 1);
    ie_full = 0; ie_req = 1;
    // R7: DMA access drops request, then it returns
    step(0, 0, 0, 1, "R7");
    check("R7 dropped", status[1], 0);
    step(0, 0, 0, 0, "R7");
    check("R7 reasserted", status[1], 1);
    // R11 and R7 together: push, pop by DMA in one cycle
    step(1, 16'h5150, 0, 1, "R11");
    check("R7 drop with pushpop", status[1], 0);
    // R6: drain toward watermark, equal holds, below clears
    while (m_cnt > 4) step(0, 0, 1, 0, "R6");
    check("R6 hold at equal", status[1], 1);
    step(0, 0, 1, 0, "R6");
    check("R6 cleared below", status[1], 0);
    step(1, 16'h0777, 0, 0, "R6");
    check("R6 hold low at equal", status[1], 0);
    step(1, 16'h0778, 1, 1, "R3");
    // R3: drain completely and pop from empty
    while (m_cnt > 0) step(0, 0, 1, 0, "R3");
    step(0, 0, 1, 0, "R3");
    step(0, 0, 0, 1, "R3");
    check("R3 empty level", level, 0);
    // R8: receiver disabled, flags forced low while level grows
    rx_en = 0;
    for (int i = 0; i < 6; i++) step(1, WIDTH'(16'hB000 + i), 0, 0, "R8");
    check("R8 request gated", status[1], 0);
    check("R8 level kept", level, 6);
    rx_en = 1;
    step(0, 0, 0, 0, "R5");
    check("R5 request after enable", status[1], 1);
    while (m_cnt > 0) step(0, 0, 1, 0, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule